// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds two 32-bit single-precision floating-point operands in a four-stage pipeline. It accepts one operation on every clock. A valid flag travels with each operation and comes out together with its result exactly four cycles later. The stages run in this order:

1. Compare the exponents and swap the operands so that the first one holds the larger exponent.
2. Restore the implicit leading one, shift the smaller significand right by the exponent difference, and keep guard, round and sticky bits. When the signs differ, the aligned significand is replaced by its two's complement.
3. Add the significands.
4. Normalize, round to nearest with ties to even, and pack the result.

Infinities and NaNs are detected at the inputs and bypass the arithmetic. Subnormal inputs are read as zero. Results that fall below the normal range are returned as +0.

Top module: `fp_add_pipe`

## Requirements
- R1: A word is laid out as sign in bit 31, biased exponent in bits 30..23 and fraction in bits 22..0. For two normal finite operands, the sum is the exact sum rounded to single precision.
- R2: `out_valid` and `sum` appear exactly four clock edges after the edge that captured `in_valid` and the operands. Back-to-back operations are accepted on consecutive cycles. `out_valid` is 0 in every other cycle and while `rst_n` is low.
- R3: The result does not depend on operand order: a+b equals b+a, including when the exponents are equal.
- R4: When the signs differ, the magnitudes are subtracted. The result takes the sign of the operand with the larger magnitude.
- R5: If either operand is a NaN (exponent 255, nonzero fraction), or the operands are infinities of opposite sign, the result is the quiet NaN 32'h7FC00000.
- R6: An infinity (exponent 255, zero fraction) added to a finite value, or to an infinity of the same sign, returns that infinity.
- R7: If the rounded exponent reaches 255, the result is infinity with the result sign: 32'h7F800000 or 32'hFF800000.
- R8: An exact zero sum returns +0 (32'h00000000). This includes x + (−x) and (−0) + (−0).
- R9: An operand with exponent 0 is read as zero. If the normalized exponent before rounding is below 1, the result is +0, so the block never outputs a subnormal.
- R10: Rounding is to nearest. An exact tie goes to the value with an even last fraction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; clears the valid flags |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be added |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | `sum` holds a result |
| sum | output | 32 | Rounded sum |

## Verification
The latency checks assume the valid flag is a clean 0 or 1 on every clock once reset is released. The bench never leaves it unknown and holds it low throughout reset. The operand checks inside the block assume only that the operand bits are known whenever `in_valid` is high. The stimulus therefore always drives full 32-bit patterns: hand-picked special and boundary words, plus random words whose exponents are placed near each other so that alignment, cancellation and rounding are all reached.

// File: rtl/fp_add_pipe.sv
module fp_add_pipe (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] sum
);
  localparam logic [31:0] QNAN = 32'h7FC00000;

  // stage 1: classify, flush, swap
  logic [7:0] ea, eb;
  logic       za, zb, na, nb, ia, ib, swap, spec;
  logic [31:0] spec_val;
  assign ea = op_a[30:23];
  assign eb = op_b[30:23];
  assign za = (ea == 8'd0);
  assign zb = (eb == 8'd0);
  assign na = (ea == 8'hFF) && (op_a[22:0] != 23'd0);
  assign nb = (eb == 8'hFF) && (op_b[22:0] != 23'd0);
  assign ia = (ea == 8'hFF) && (op_a[22:0] == 23'd0);
  assign ib = (eb == 8'hFF) && (op_b[22:0] == 23'd0);
  assign swap = (ea < eb);
  assign spec = na | nb | ia | ib;
  assign spec_val = (na | nb | (ia & ib & (op_a[31] ^ op_b[31]))) ? QNAN :
                    ia ? op_a : op_b;

  logic        v1, sp1, sx1, sy1;
  logic [31:0] spv1;
  logic [7:0]  ex1, ey1;
  logic [23:0] mx1, my1;
  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
    sp1  <= spec;
    spv1 <= spec_val;
    sx1  <= swap ? op_b[31] : op_a[31];
    sy1  <= swap ? op_a[31] : op_b[31];
    ex1  <= swap ? eb : ea;
    ey1  <= swap ? ea : eb;
    mx1  <= swap ? (zb ? 24'd0 : {1'b1, op_b[22:0]}) : (za ? 24'd0 : {1'b1, op_a[22:0]});
    my1  <= swap ? (za ? 24'd0 : {1'b1, op_a[22:0]}) : (zb ? 24'd0 : {1'b1, op_b[22:0]});
  end

  // stage 2: align with guard/round/sticky, complement on unlike signs
  logic [7:0]  dexp;
  logic [4:0]  dsh;
  logic [50:0] wide;
  logic [26:0] al;
  assign dexp = ex1 - ey1;
  assign dsh  = (dexp > 8'd27) ? 5'd27 : dexp[4:0];
  assign wide = {my1, 27'd0} >> dsh;
  assign al   = {wide[50:25], |wide[24:0]};

  logic        v2, sp2, sx2, sy2;
  logic [31:0] spv2;
  logic [7:0]  ex2;
  logic [26:0] mx2;
  logic [28:0] my2;
  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
    sp2  <= sp1;
    spv2 <= spv1;
    sx2  <= sx1;
    sy2  <= sy1;
    ex2  <= ex1;
    mx2  <= {mx1, 3'b000};
    my2  <= (sx1 ^ sy1) ? (~{2'b00, al} + 29'd1) : {2'b00, al};
  end

  // stage 3: add
  logic [28:0] raw;
  assign raw = {2'b00, mx2} + my2;

  logic        v3, sp3, sg3;
  logic [31:0] spv3;
  logic [7:0]  ex3;
  logic [27:0] mag3;
  always_ff @(posedge clk) begin
    if (!rst_n) v3 <= 1'b0;
    else        v3 <= v2;
    sp3  <= sp2;
    spv3 <= spv2;
    sg3  <= raw[28] ? sy2 : sx2;
    ex3  <= ex2;
    mag3 <= raw[28] ? (~raw[27:0] + 28'd1) : raw[27:0];
  end

  // stage 4: normalize and round to nearest even
  logic [4:0]  lz;
  logic [26:0] norm;
  logic signed [10:0] e_pre, e_fin;
  logic        up;
  logic [24:0] rnd;
  logic [31:0] res;
  always_comb begin
    lz = 5'd27;
    for (int i = 0; i < 27; i++)
      if (mag3[i]) lz = 5'(26 - i);
    if (mag3[27]) begin
      norm  = {mag3[27:2], mag3[1] | mag3[0]};
      e_pre = $signed({3'b000, ex3}) + 11'sd1;
    end else begin
      norm  = mag3[26:0] << lz;
      e_pre = $signed({3'b000, ex3}) - $signed({6'b0, lz});
    end
    up    = norm[2] & (norm[1] | norm[0] | norm[3]);
    rnd   = {1'b0, norm[26:3]} + {24'd0, up};
    e_fin = e_pre + $signed({10'd0, rnd[24]});
    if (sp3)                         res = spv3;
    else if (mag3 == 28'd0)          res = 32'd0;
    else if (e_pre < 11'sd1)         res = 32'd0;
    else if (e_fin > 11'sd254)       res = {sg3, 8'hFF, 23'd0};
    else res = {sg3, e_fin[7:0], rnd[24] ? rnd[23:1] : rnd[22:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v3;
    sum <= res;
  end

  // edges seen since reset release, saturating at 4
  logic [2:0] live;
  always_ff @(posedge clk)
    if (!rst_n) live <= 3'd0;
    else if (live != 3'd4) live <= live + 3'd1;

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 3'd4) |-> (out_valid == $past(in_valid, 4)));
  // R5
  nan_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 3'd4 && $past(in_valid, 4) &&
     $past(op_a[30:23], 4) == 8'hFF && $past(op_a[22:0], 4) != 23'd0) |-> (sum == QNAN));
  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 3'd4 && $past(in_valid, 4) && $past(op_a[30:23], 4) != 8'hFF &&
     $past(op_b, 4) == ($past(op_a, 4) ^ 32'h80000000)) |-> (sum == 32'd0));
  // R9
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sum[30:23] == 8'd0) |-> (sum == 32'd0));
  // R6
  inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 3'd4 && $past(in_valid, 4) && $past(op_a[30:0], 4) == 31'h7F800000 &&
     $past(op_b[30:23], 4) != 8'hFF) |-> (sum == $past(op_a, 4)));
endmodule

// File: tb/fp_add_pipe_tb.sv
module fp_add_pipe_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] op_a = 32'd0, op_b = 32'd0;
  logic out_valid;
  logic [31:0] sum;

  fp_add_pipe u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                     .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .sum(sum));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic [7:0] ea, eb;
    logic [299:0] A, B, M, mask;
    logic sg, g, st;
    logic [23:0] sig;
    logic [24:0] s25;
    int p, E;
    ea = a[30:23]; eb = b[30:23];
    if ((ea == 8'hFF && a[22:0] != 0) || (eb == 8'hFF && b[22:0] != 0)) return 32'h7FC00000;
    if (ea == 8'hFF && eb == 8'hFF) return (a[31] != b[31]) ? 32'h7FC00000 : a;
    if (ea == 8'hFF) return a;
    if (eb == 8'hFF) return b;
    A = (ea == 0) ? 300'd0 : (300'({1'b1, a[22:0]}) << (ea - 1));
    B = (eb == 0) ? 300'd0 : (300'({1'b1, b[22:0]}) << (eb - 1));
    if (a[31] == b[31]) begin M = A + B; sg = a[31]; end
    else if (A >= B)    begin M = A - B; sg = a[31]; end
    else                begin M = B - A; sg = b[31]; end
    if (M == 0) return 32'd0;
    p = 0;
    for (int i = 0; i < 300; i++) if (M[i]) p = i;
    E = p - 22;
    if (E < 1) return 32'd0;
    sig = 24'(M >> (p - 23));
    if (p >= 24) begin
      g = M[p-24];
      mask = (300'd1 << (p - 24)) - 300'd1;
      st = ((M & mask) != 0);
    end else begin g = 1'b0; st = 1'b0; end
    s25 = {1'b0, sig} + 25'(g & (st | sig[0]));
    if (s25[24]) begin E = E + 1; s25 = s25 >> 1; end
    if (E >= 255) return {sg, 8'hFF, 23'd0};
    return {sg, 8'(E), s25[22:0]};
  endfunction

  task automatic compare();
    bit expv;
    expv = (due_q.size() > 0) && (due_q[0] == cyc);
    checks++;
    if (out_valid !== expv) begin
      fails++;
      $display("FAIL R2 cycle %0d out_valid actual %b expected %b", cyc, out_valid, expv);
    end
    if (expv) begin
      checks++;
      if (sum !== exp_q[0]) begin
        fails++;
        $display("FAIL %s sum actual %h expected %h", tag_q[0], sum, exp_q[0]);
      end
      void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    compare();
    in_valid = v; op_a = a; op_b = b;
    if (v) begin
      exp_q.push_back(ref_add(a, b)); due_q.push_back(cyc + 4); tag_q.push_back(tag);
    end
  endtask

  function automatic logic [31:0] near(input logic [31:0] x);
    int e;
    e = int'(x[30:23]) + int'($urandom_range(0, 60)) - 30;
    if (e < 0) e = 0;
    if (e > 254) e = 254;
    return {1'($urandom), 8'(e), 23'($urandom)};
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R2 reset out_valid actual %b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;
    step(1, 32'h3F800000, 32'h3F800000, "R1 one plus one");
    step(1, 32'h3FC00000, 32'h40100000, "R1 1.5+2.25");
    step(1, 32'h40100000, 32'h3FC00000, "R3 swapped order");
    step(1, 32'h3F800001, 32'h3F800003, "R3 equal exponents");
    step(1, 32'h3F800003, 32'h3F800001, "R3 equal exponents swapped");
    step(1, 32'h3F800000, 32'h33800000, "R10 tie to even down");
    step(1, 32'h3F800001, 32'h33800000, "R10 tie to even up");
    step(1, 32'h3F800000, 32'h33800001, "R10 above half");
    step(1, 32'h3F800000, 32'hBF400000, "R4 1-0.75");
    step(1, 32'hC0000000, 32'h3F800000, "R4 -2+1");
    step(1, 32'h3F800000, 32'hBF800001, "R4 near cancel negative");
    step(0, 32'h0, 32'h0, "");
    step(1, 32'h7FC00000, 32'h3F800000, "R5 quiet NaN in");
    step(1, 32'h3F800000, 32'h7F800001, "R5 signalling NaN in");
    step(1, 32'h7F800000, 32'hFF800000, "R5 inf minus inf");
    step(1, 32'h7F800000, 32'h447A0000, "R6 +inf plus finite");
    step(1, 32'h40A00000, 32'hFF800000, "R6 finite plus -inf");
    step(1, 32'hFF800000, 32'hFF800000, "R6 like infinities");
    step(1, 32'h7F7FFFFF, 32'h7F7FFFFF, "R7 overflow positive");
    step(1, 32'hFF7FFFFF, 32'hFF7FFFFF, "R7 overflow negative");
    step(1, 32'h7F7FFFFF, 32'h73000000, "R7 overflow by rounding");
    step(1, 32'h41200000, 32'hC1200000, "R8 x minus x");
    step(1, 32'h80000000, 32'h80000000, "R8 -0 plus -0");
    step(1, 32'h00000000, 32'h40A00000, "R8 zero plus five");
    step(1, 32'h00000001, 32'h3F800000, "R9 subnormal input");
    step(1, 32'h00400000, 32'h80000000, "R9 subnormal plus zero");
    step(1, 32'h00800001, 32'h80800000, "R9 underflow to zero");
    step(1, 32'h00800000, 32'h00800000, "R9 smallest normal doubled");
    step(0, 32'h0, 32'h0, "");
    step(0, 32'h0, 32'h0, "");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] x, y;
      x = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
      y = ($urandom_range(0, 3) == 0) ? {~x[31], x[30:23], 23'($urandom)} : near(x);
      if ($urandom_range(0, 7) == 0) step(0, x, y, "");
      else step(1, x, y, (k % 2 == 0) ? "R1 random" : "R4 random mixed signs");
    end
    repeat (6) step(0, 32'h0, 32'h0, "");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule